// File: doc/BRIEF.md
# Receive Frame Ring Writer

This block takes an incoming Ethernet frame as a byte stream with start and end flags. It decides whether to keep the frame, and if it does, stores the frame as one record in a page-organised packet buffer. The buffer is addressed as 256-byte pages. Received records form a circular ring between a programmable first page and a programmable limit page. Each record starts at the base of the current receive page. Four header bytes come first, giving a status code, the page where the next record will start, and the record length. The frame bytes follow the header, and any address that reaches the limit page wraps back to the first page.

The keep/drop decision uses an 8-bit receive mode byte and a 48-bit station address. The first six frame bytes wait in a staging register until the decision is made, so a dropped frame never touches the buffer. Buffer writes leave the block on a registered byte-wide write port, which connects to an external dual-port block RAM. After the header is written, the current receive page moves to the next record and the block raises a one-cycle receive-done event. The block lowers `in_ready` while it is emptying the staging register, writing pad bytes or writing the header. A source must hold its byte until it is accepted.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset the current receive page reads 0x4C, the ring spans first page 0x40 up to limit page 0x80 (exclusive), no buffer write or done event is pending, and `in_ready` is 1.
- R2: A kept frame's record header occupies byte offsets 0..3 of the page that was current at the frame's start byte: 0x01, then the next-record page, then the record length low byte, then its high byte. Record length is the stored frame length plus 4.
- R3: Frame bytes are written in arrival order, starting at offset 4 of the record's page and rising by one address per byte.
- R4: A kept frame of fewer than 60 bytes is stored as 60 bytes, and the bytes after the last received one are written as 0x00.
- R5: A frame-byte address whose page would reach the limit page continues at offset 0 of the first page.
- R6: Next page = record page + 1 + (record length >> 8), reduced by (limit − first) when it is at or past the limit page. `cur_page` takes this value in the same cycle in which `rx_done` is high for exactly one cycle, once per kept frame.
- R7: With mode bit 4 set, every frame of six or more bytes is kept.
- R8: With mode bit 4 clear and mode bit 2 set, a frame whose six destination bytes are all 0xFF is kept.
- R9: Otherwise, with mode bit 3 set, a frame whose first byte has bit 0 set is dropped.
- R10: Any other frame is kept only when its first six bytes equal `station_addr`, where bits [7:0] hold the first byte and bits [47:40] the sixth. A dropped frame produces no buffer write, no done event and no change of `cur_page`.
- R11: A frame whose start byte arrives while `rx_stop` is 1 is consumed and dropped.
- R12: A frame that ends before its sixth byte is dropped.
- R13: When `cfg_we` is 1, `cfg_wdata` loads the first page (`cfg_sel`=0), the limit page (1) or the current receive page (2).
- R14: A byte is taken only when `in_valid` and `in_ready` are both 1. `in_ready` is 0 while staged bytes, pad bytes or header bytes are being written. A byte taken while idle without `in_sof` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Frame byte present |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_data | input | 8 | Frame byte |
| in_ready | output | 1 | Block can take a byte this cycle |
| rx_stop | input | 1 | Receiver halted; frames starting now are ignored |
| rx_mode | input | 8 | Receive mode: bit 4 keep all, bit 2 keep broadcast, bit 3 drop group |
| station_addr | input | 48 | Station address, first byte in bits [7:0] |
| cfg_we | input | 1 | Page register write strobe |
| cfg_sel | input | 2 | 0 first page, 1 limit page, 2 current page |
| cfg_wdata | input | 8 | Page register write value |
| mem_we | output | 1 | Buffer write strobe |
| mem_addr | output | 16 | Buffer byte address (page, offset) |
| mem_wdata | output | 8 | Buffer write byte |
| cur_page | output | 8 | Current receive page |
| rx_done | output | 1 | One-cycle frame-stored event |

## Verification
The bench uses the default 8-bit page number, 16-bit length and 60-byte minimum frame. For most of the run it shrinks the ring to four pages (0x40 to 0x44). With that small ring, frames of a few hundred bytes wrap the data address and the next-record page many times, from every starting page. A sweep over all frame lengths from 1 to 80 covers the short-frame drop, the zero pad and the 60-byte edge. A second sweep over all eight settings of the three mode bits, against own, broadcast, other-group and foreign destinations, covers every filter priority path.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_COLLECT,
    S_DECIDE,
    S_FLUSH,
    S_STREAM,
    S_PAD,
    S_HDR,
    S_DROP
  } rxr_state_e;

  localparam int unsigned DEST_BYTES  = 6;
  localparam int unsigned HDR_BYTES   = 4;
  localparam logic [7:0]  REC_OK      = 8'h01;

  localparam int unsigned MODE_ALL    = 4;
  localparam int unsigned MODE_BCAST  = 2;
  localparam int unsigned MODE_GROUP  = 3;

  localparam logic [1:0]  SEL_FIRST   = 2'd0;
  localparam logic [1:0]  SEL_LIMIT   = 2'd1;
  localparam logic [1:0]  SEL_CUR     = 2'd2;

endpackage

// File: rtl/rx_ring_filter.sv
module rx_ring_filter
  import rx_ring_pkg::*;
#(
  parameter int unsigned NB = DEST_BYTES
) (
  input  logic [8*NB-1:0] dest,
  input  logic [8*NB-1:0] station,
  input  logic [7:0]      mode,
  output logic            keep
);

  logic [NB-1:0] byte_eq;
  logic [NB-1:0] byte_ff;
  logic          unused_mode;

  assign unused_mode = ^{mode[7:5], mode[1:0]};

  generate
    for (genvar g = 0; g < NB; g++) begin : g_cmp
      assign byte_eq[g] = (dest[8*g +: 8] == station[8*g +: 8]);
      assign byte_ff[g] = &dest[8*g +: 8];
    end
  endgenerate

  always_comb begin
    if (mode[MODE_ALL]) begin
      keep = 1'b1;
    end else if (mode[MODE_BCAST] && (&byte_ff)) begin
      keep = 1'b1;
    end else if (mode[MODE_GROUP] && dest[0]) begin
      keep = 1'b0;
    end else begin
      keep = &byte_eq;
    end
  end

endmodule

// File: rtl/rx_ring_nextpg.sv
module rx_ring_nextpg #(
  parameter int unsigned PG_W  = 8,
  parameter int unsigned LEN_W = 16
) (
  input  logic [PG_W-1:0]  base_pg,
  input  logic [PG_W-1:0]  first_pg,
  input  logic [PG_W-1:0]  limit_pg,
  input  logic [LEN_W-1:0] rec_len,
  output logic [PG_W-1:0]  next_pg
);

  localparam int unsigned W = LEN_W + PG_W + 1;

  logic [W-1:0] raw;
  logic [W-1:0] span;

  assign raw  = W'(base_pg) + W'(1) + W'(rec_len >> 8);
  assign span = W'(limit_pg) - W'(first_pg);

  always_comb begin
    if (raw >= W'(limit_pg)) next_pg = PG_W'(raw - span);
    else                     next_pg = PG_W'(raw);
  end

endmodule

// File: rtl/rx_ring_addr.sv
module rx_ring_addr #(
  parameter int unsigned PG_W = 8
) (
  input  logic [PG_W+7:0] addr,
  input  logic [PG_W-1:0] first_pg,
  input  logic [PG_W-1:0] limit_pg,
  output logic [PG_W+7:0] addr_next
);

  logic [PG_W+7:0] bump;

  assign bump = addr + (PG_W+8)'(1);

  always_comb begin
    if (bump[PG_W+7:8] >= limit_pg) addr_next = {first_pg, 8'h00};
    else                            addr_next = bump;
  end

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rx_ring_pkg::*;
#(
  parameter int unsigned PG_W      = 8,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned MIN_FRAME = 60,
  parameter int unsigned FIRST_RST = 'h40,
  parameter int unsigned LIMIT_RST = 'h80,
  parameter int unsigned CUR_RST   = 'h4C
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    in_sof,
  input  logic                    in_eof,
  input  logic [7:0]              in_data,
  output logic                    in_ready,
  input  logic                    rx_stop,
  input  logic [7:0]              rx_mode,
  input  logic [8*DEST_BYTES-1:0] station_addr,
  input  logic                    cfg_we,
  input  logic [1:0]              cfg_sel,
  input  logic [PG_W-1:0]         cfg_wdata,
  output logic                    mem_we,
  output logic [PG_W+7:0]         mem_addr,
  output logic [7:0]              mem_wdata,
  output logic [PG_W-1:0]         cur_page,
  output logic                    rx_done
);

  localparam int unsigned AW = PG_W + 8;
  localparam logic [2:0]  LAST_STAGE = 3'(DEST_BYTES - 1);

  rxr_state_e              st;
  logic [PG_W-1:0]         first_pg, limit_pg, frame_pg;
  logic [AW-1:0]           wptr, wptr_next;
  logic [LEN_W-1:0]        cnt, rec_len;
  logic [2:0]              idx;
  logic                    eof_seen;
  logic [8*DEST_BYTES-1:0] stage;
  logic                    keep;
  logic [PG_W-1:0]         next_pg;
  logic                    take;

  assign in_ready = (st == S_IDLE) || (st == S_COLLECT) ||
                    (st == S_STREAM) || (st == S_DROP);
  assign take     = in_valid && in_ready;
  assign rec_len  = cnt + LEN_W'(HDR_BYTES);

  rx_ring_filter #(.NB(DEST_BYTES)) u_filter (
    .dest    (stage),
    .station (station_addr),
    .mode    (rx_mode),
    .keep    (keep)
  );

  rx_ring_nextpg #(.PG_W(PG_W), .LEN_W(LEN_W)) u_nextpg (
    .base_pg  (frame_pg),
    .first_pg (first_pg),
    .limit_pg (limit_pg),
    .rec_len  (rec_len),
    .next_pg  (next_pg)
  );

  rx_ring_addr #(.PG_W(PG_W)) u_addr (
    .addr      (wptr),
    .first_pg  (first_pg),
    .limit_pg  (limit_pg),
    .addr_next (wptr_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      first_pg  <= PG_W'(FIRST_RST);
      limit_pg  <= PG_W'(LIMIT_RST);
      cur_page  <= PG_W'(CUR_RST);
      frame_pg  <= PG_W'(CUR_RST);
      wptr      <= '0;
      cnt       <= '0;
      idx       <= '0;
      eof_seen  <= 1'b0;
      stage     <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rx_done   <= 1'b0;
    end else begin
      mem_we  <= 1'b0;
      rx_done <= 1'b0;

      if (cfg_we) begin
        case (cfg_sel)
          SEL_FIRST: first_pg <= cfg_wdata;
          SEL_LIMIT: limit_pg <= cfg_wdata;
          SEL_CUR:   cur_page <= cfg_wdata;
          default: ;
        endcase
      end

      case (st)
        S_IDLE: begin
          if (take && in_sof) begin
            frame_pg <= cur_page;
            wptr     <= {cur_page, 8'h04};
            eof_seen <= 1'b0;
            if (rx_stop) begin
              st <= in_eof ? S_IDLE : S_DROP;
            end else begin
              stage[7:0] <= in_data;
              cnt        <= LEN_W'(1);
              st         <= in_eof ? S_IDLE : S_COLLECT;
            end
          end
        end
        S_COLLECT: begin
          if (take) begin
            stage[{cnt[2:0], 3'b000} +: 8] <= in_data;
            cnt <= cnt + LEN_W'(1);
            if (cnt[2:0] == LAST_STAGE) begin
              st       <= S_DECIDE;
              eof_seen <= in_eof;
            end else if (in_eof) begin
              st <= S_IDLE;
            end
          end
        end
        S_DECIDE: begin
          idx <= '0;
          if (keep)          st <= S_FLUSH;
          else if (eof_seen) st <= S_IDLE;
          else               st <= S_DROP;
        end
        S_FLUSH: begin
          mem_we    <= 1'b1;
          mem_addr  <= wptr;
          mem_wdata <= stage[{idx, 3'b000} +: 8];
          wptr      <= wptr_next;
          idx       <= idx + 3'd1;
          if (idx == LAST_STAGE) st <= eof_seen ? S_PAD : S_STREAM;
        end
        S_STREAM: begin
          if (take) begin
            mem_we    <= 1'b1;
            mem_addr  <= wptr;
            mem_wdata <= in_data;
            wptr      <= wptr_next;
            cnt       <= cnt + LEN_W'(1);
            if (in_eof) st <= S_PAD;
          end
        end
        S_PAD: begin
          if (cnt < LEN_W'(MIN_FRAME)) begin
            mem_we    <= 1'b1;
            mem_addr  <= wptr;
            mem_wdata <= 8'h00;
            wptr      <= wptr_next;
            cnt       <= cnt + LEN_W'(1);
          end else begin
            st  <= S_HDR;
            idx <= '0;
          end
        end
        S_HDR: begin
          mem_we   <= 1'b1;
          mem_addr <= {frame_pg, 6'd0, idx[1:0]};
          case (idx[1:0])
            2'd0:    mem_wdata <= REC_OK;
            2'd1:    mem_wdata <= 8'(next_pg);
            2'd2:    mem_wdata <= rec_len[7:0];
            default: mem_wdata <= 8'(rec_len >> 8);
          endcase
          idx <= idx + 3'd1;
          if (idx[1:0] == 2'd3) begin
            cur_page <= next_pg;
            rx_done  <= 1'b1;
            st       <= S_IDLE;
          end
        end
        S_DROP: begin
          if (take && in_eof) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic ring_ok;
  assign ring_ok = (first_pg < limit_pg) && (frame_pg >= first_pg) &&
                   (frame_pg < limit_pg);

  // R5: every buffer write of a record in a sane ring lands inside the ring
  a_r5_addr_in_ring: assert property (@(posedge clk) disable iff (rst)
    (mem_we && ring_ok) |->
      (mem_addr[AW-1:8] >= first_pg && mem_addr[AW-1:8] < limit_pg));

  // R6: the done event lasts a single cycle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> !rx_done);

  // R2: the first header write is the status code at the page base
  a_r2_status_first: assert property (@(posedge clk) disable iff (rst)
    (st == S_HDR && idx == 3'd0) |=>
      (mem_we && mem_wdata == REC_OK && mem_addr[7:0] == 8'h00));

  // R4: a pad cycle writes a zero byte
  a_r4_pad_zero: assert property (@(posedge clk) disable iff (rst)
    (st == S_PAD && cnt < LEN_W'(MIN_FRAME)) |=> (mem_we && mem_wdata == 8'h00));

  // R10: a frame being discarded causes no buffer write
  a_r10_drop_quiet: assert property (@(posedge clk) disable iff (rst)
    (st == S_DROP) |=> !mem_we);

endmodule

// File: tb/rx_ring_writer_test.sv
`timescale 1ns/1ps
module rx_ring_writer_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready;
  logic        rx_stop = 1'b0;
  logic [7:0]  rx_mode = 8'h00;
  logic [47:0] station_addr = {8'h55, 8'h44, 8'h33, 8'h22, 8'h11, 8'h02};
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  cur_page;
  logic        rx_done;

  always #2 clk = ~clk;

  rx_ring_writer uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_data(in_data), .in_ready(in_ready), .rx_stop(rx_stop), .rx_mode(rx_mode),
    .station_addr(station_addr), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .cur_page(cur_page), .rx_done(rx_done)
  );

  int model [int];
  int wr_cnt = 0, done_cnt = 0;
  int vectors = 0, fails = 0;
  int tb_first = 'h40, tb_limit = 'h80;
  logic [7:0] frm [0:1023];
  bit summary_done = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (mem_we) begin
        model[int'(mem_addr)] = int'(mem_wdata);
        wr_cnt++;
      end
      if (rx_done) done_cnt++;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  task automatic cfg_write(logic [1:0] sel, logic [7:0] val);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel == 2'd0) tb_first = int'(val);
    if (sel == 2'd1) tb_limit = int'(val);
  endtask

  task automatic put(logic [7:0] b, logic s, logic e, bit gap);
    in_valid = 1'b1; in_data = b; in_sof = s; in_eof = e;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    if (gap) @(negedge clk);
  endtask

  task automatic build(int kind, int len, int seed);
    for (int i = 0; i < len; i++) frm[i] = 8'((i * 7 + seed) & 255);
    for (int i = 0; i < 6; i++) begin
      case (kind)
        0: frm[i] = station_addr[8*i +: 8];
        1: frm[i] = 8'hFF;
        2: frm[i] = (i == 0) ? 8'h01 : 8'(8'h30 + i);
        default: frm[i] = (i == 5) ? 8'h56 : station_addr[8*i +: 8];
      endcase
    end
  endtask

  function automatic bit want(logic [7:0] m, int kind);
    if (m[4]) return 1;
    if (m[2] && kind == 1) return 1;
    if (m[3] && (kind == 1 || kind == 2)) return 0;
    return kind == 0;
  endfunction

  task automatic run_frame(int kind, int len, int seed, logic [7:0] m, bit acc, bit gap,
                           string tag);
    int pg0, d0, stored, total, nxt, a, w;
    bit crossed;
    pg0 = int'(cur_page);
    d0 = done_cnt;
    model.delete();
    wr_cnt = 0;
    rx_mode = m;
    build(kind, len, seed);
    for (int i = 0; i < len; i++) put(frm[i], i == 0, i == len - 1, gap);
    if (acc) begin
      w = 0;
      while (done_cnt == d0 && w < 4000) begin @(negedge clk); w++; end
      stored = (len < 60) ? 60 : len;
      total = stored + 4;
      nxt = pg0 + 1 + (total >> 8);
      if (nxt >= tb_limit) nxt = nxt - (tb_limit - tb_first);
      a = pg0 * 256;
      chk(done_cnt == d0 + 1, {tag, " R6 done count"}, done_cnt - d0, 1);
      chk(model.exists(a) && model[a] == 1, {tag, " R2 status"},
          model.exists(a) ? model[a] : -1, 1);
      chk(model.exists(a+1) && model[a+1] == (nxt & 255), {tag, " R6 next page field"},
          model.exists(a+1) ? model[a+1] : -1, nxt);
      chk(model.exists(a+2) && model[a+2] == (total & 255), {tag, " R2 length low"},
          model.exists(a+2) ? model[a+2] : -1, total & 255);
      chk(model.exists(a+3) && model[a+3] == (total >> 8), {tag, " R2 length high"},
          model.exists(a+3) ? model[a+3] : -1, total >> 8);
      chk(int'(cur_page) == nxt, {tag, " R6 current page"}, int'(cur_page), nxt);
      chk(wr_cnt == total, {tag, " R3 write count"}, wr_cnt, total);
      a = pg0 * 256 + 4;
      crossed = 0;
      for (int i = 0; i < stored; i++) begin
        int ev, av;
        ev = (i < len) ? int'(frm[i]) : 0;
        av = model.exists(a) ? model[a] : -1;
        if (i >= len)     chk(av == ev, {tag, " R4 pad byte"}, av, ev);
        else if (crossed) chk(av == ev, {tag, " R5 wrapped byte"}, av, ev);
        else              chk(av == ev, {tag, " R3 frame byte"}, av, ev);
        a++;
        if ((a >> 8) >= tb_limit) begin a = tb_first * 256; crossed = 1; end
      end
    end else begin
      repeat (20) @(negedge clk);
      chk(wr_cnt == 0, {tag, " R10 no write on drop"}, wr_cnt, 0);
      chk(done_cnt == d0, {tag, " R10 no done on drop"}, done_cnt - d0, 0);
      chk(int'(cur_page) == pg0, {tag, " R10 page kept"}, int'(cur_page), pg0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cur_page == 8'h4C, "R1 reset page", int'(cur_page), 'h4C);
    chk(mem_we == 1'b0, "R1 no write", int'(mem_we), 0);
    chk(rx_done == 1'b0, "R1 no done", int'(rx_done), 0);
    chk(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);
    run_frame(0, 60, 3, 8'h00, 1, 0, "R1 first frame");
    // R1 reset ring bounds: record at 0x7F wraps data and next page
    cfg_write(2'd2, 8'h7F);
    run_frame(0, 300, 5, 8'h10, 1, 0, "R1 ring bounds");
    // R13 shrink the ring to four pages
    cfg_write(2'd0, 8'h40);
    cfg_write(2'd1, 8'h44);
    cfg_write(2'd2, 8'h40);
    chk(cur_page == 8'h40, "R13 page load", int'(cur_page), 'h40);
    // R12/R4 length sweep, own station address
    for (int len = 1; len <= 80; len++)
      run_frame(0, len, len, 8'h00, len >= 6, len[0], "R12 length sweep");
    for (int len = 200; len <= 560; len += 23)
      run_frame(0, len, len, 8'h00, 1, 0, "R5 long sweep");
    // R7 R8 R9 R10 filter sweep
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 4; k++) begin
        logic [7:0] m;
        m = {3'b000, c[2], c[1], c[0], 2'b00};
        run_frame(k, 64, c * 4 + k, m, want(m, k), 0, "R7 R8 R9 filter");
      end
    end
    // R11 halted receiver
    rx_stop = 1'b1;
    run_frame(0, 64, 9, 8'h10, 0, 0, "R11 stop");
    rx_stop = 1'b0;
    // R14 bytes without a start flag while idle
    begin
      int d0;
      d0 = done_cnt; wr_cnt = 0;
      for (int i = 0; i < 10; i++) put(8'(i), 1'b0, i == 9, 0);
      repeat (20) @(negedge clk);
      chk(wr_cnt == 0 && done_cnt == d0, "R14 stray bytes", wr_cnt, 0);
    end
    // R14 ready drops after end of frame while padding
    build(0, 40, 1);
    rx_mode = 8'h00;
    for (int i = 0; i < 40; i++) put(frm[i], i == 0, i == 39, 0);
    chk(in_ready == 1'b0, "R14 busy after end", int'(in_ready), 0);
    repeat (100) @(negedge clk);
    run_frame(1, 70, 2, 8'h04, 1, 1, "R14 after busy");
    summary();
  end

endmodule